// File: doc/BRIEF.md
# Auto-Reload Down-Counter Timer

A sixteen-bit timer that counts down at one of three prescaled rates of its clock. When the count is at zero and a tick arrives, the timer reloads from a reload register. It also raises a one-cycle interrupt pulse and flips a square-wave output, so the output frequency is half the reload rate and its duty is 50 %.

Software reaches the timer through an 8-bit port. A two-byte read fetches the low byte first, and that read freezes the high byte for the read that follows. A two-byte write stages the high byte, and the low-byte write then commits both bytes at once. An enable input moves the timer between standby and running.

Top module: `reload_timer`

## Requirements
- R1: After reset the counter, the reload register, `rdata`, `irq` and `tout` are all zero, and the timer is in standby.
- R2: A write with `addr_hi`=1 only stages the high byte and changes nothing a read can observe. A later write with `addr_hi`=0 loads {staged, wdata} into both the reload register and the counter.
- R3: A read with `addr_hi`=0 returns the counter's low byte on `rdata` in the next cycle and copies the counter's high byte into a latch. A read with `addr_hi`=1 returns that latched byte and not the live counter.
- R4: The timer ticks once every 2^DIV0_LOG2 clock cycles when `csel`=0, every 2^DIV1_LOG2 cycles when `csel`=1, and every 2^DIV2_LOG2 cycles when `csel`=2. With `csel`=3 it never ticks. On a tick the counter drops by one, or reloads if it is zero, so reload events are (reload+1) ticks apart.
- R5: Each reload event raises `irq` for exactly one clock cycle.
- R6: `tout` toggles on every reload event, starting from low.
- R7: When `en` rises, the counter loads from the reload register and the prescaler restarts. The first reload event then comes (reload+1) tick periods after that edge.
- R8: While `en` is low the counter holds its value and can still be read, `tout` is low, and the reload register keeps its value.
- R9: A reload value of zero produces a reload event on every tick.
- R10: A low-byte write while the timer is running restarts the count from the new value and restarts the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | 1 = running, 0 = standby |
| csel | input | 2 | Tick-rate select |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr_hi | input | 1 | 1 = high byte, 0 = low byte |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, valid the cycle after `rd_en` |
| irq | output | 1 | One-cycle reload pulse |
| tout | output | 1 | Square wave, toggled per reload |

## Verification
The bench builds the timer with DIV0_LOG2=1, DIV1_LOG2=3 and DIV2_LOG2=5, so the three tick periods are 2, 8 and 32 cycles. With those values, exact reload latencies and intervals can be measured on every rate within a few hundred cycles. The short periods also let a counter borrow across its byte boundary between two reads, which shows that the high-byte latch holds. The defaults of 2, 512 and 131072 cycles only stretch those same intervals.

// File: rtl/reload_timer.sv
module reload_timer #(
  parameter int DIV0_LOG2 = 1,
  parameter int DIV1_LOG2 = 9,
  parameter int DIV2_LOG2 = 17
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] csel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       addr_hi,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  output logic       tout
);
  localparam int PW01 = (DIV0_LOG2 > DIV1_LOG2) ? DIV0_LOG2 : DIV1_LOG2;
  localparam int PW   = (PW01 > DIV2_LOG2) ? PW01 : DIV2_LOG2;
  localparam logic [PW-1:0] M0 = PW'((64'd1 << DIV0_LOG2) - 64'd1);
  localparam logic [PW-1:0] M1 = PW'((64'd1 << DIV1_LOG2) - 64'd1);
  localparam logic [PW-1:0] M2 = PW'((64'd1 << DIV2_LOG2) - 64'd1);

  logic [PW-1:0] pre_q;
  logic [15:0]   cnt_q, reload_q;
  logic [7:0]    stage_q, hold_q;
  logic          en_q, tick, wr_lo, start, zero_evt;

  always_comb begin
    case (csel)
      2'd0:    tick = (pre_q & M0) == M0;
      2'd1:    tick = (pre_q & M1) == M1;
      2'd2:    tick = (pre_q & M2) == M2;
      default: tick = 1'b0;
    endcase
  end

  assign wr_lo    = wr_en & ~addr_hi;
  assign start    = en & ~en_q;
  assign zero_evt = en & en_q & tick & ~wr_lo & (cnt_q == 16'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q    <= '0;
      cnt_q    <= '0;
      reload_q <= '0;
      stage_q  <= '0;
      hold_q   <= '0;
      rdata    <= '0;
      en_q     <= 1'b0;
      irq      <= 1'b0;
      tout     <= 1'b0;
    end else begin
      en_q <= en;
      irq  <= zero_evt;
      pre_q <= (wr_lo | start) ? '0 : pre_q + 1'b1;

      if (wr_en & addr_hi) stage_q <= wdata;
      if (wr_lo) reload_q <= {stage_q, wdata};

      if (wr_lo)            cnt_q <= {stage_q, wdata};
      else if (start)       cnt_q <= reload_q;
      else if (en && tick)  cnt_q <= (cnt_q == 16'd0) ? reload_q : cnt_q - 16'd1;

      if (!en)           tout <= 1'b0;
      else if (zero_evt) tout <= ~tout;

      if (rd_en) begin
        if (addr_hi) rdata <= hold_q;
        else begin
          rdata  <= cnt_q[7:0];
          hold_q <= cnt_q[15:8];
        end
      end
    end
  end
endmodule

// File: rtl/reload_timer_chk.sv
module reload_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic        en_q,
  input logic        tick,
  input logic        wr_lo,
  input logic [15:0] cnt_q,
  input logic        irq,
  input logic        tout
);
  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && en_q && tick && !wr_lo && cnt_q != 16'd0) |=> (cnt_q == $past(cnt_q) - 16'd1));
  a_r9_zero_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (en && en_q && tick && !wr_lo && cnt_q == 16'd0) |=> irq);
  a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  a_r6_toggle_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tout) |-> (irq || !tout));
  a_r8_standby_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !tout);
  a_r8_standby_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr_lo) |=> $stable(cnt_q));
endmodule

bind reload_timer reload_timer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .en_q(en_q), .tick(tick),
  .wr_lo(wr_lo), .cnt_q(cnt_q), .irq(irq), .tout(tout)
);

// File: tb/reload_timer_tb_top.sv
module reload_timer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, wr_en = 1'b0, rd_en = 1'b0, addr_hi = 1'b0;
  logic [1:0] csel = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic irq, tout;
  int n_vec = 0, n_bad = 0, cyc = 0;
  bit done = 0;
  logic rd_seen = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  reload_timer #(.DIV0_LOG2(1), .DIV1_LOG2(3), .DIV2_LOG2(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .csel(csel), .wr_en(wr_en), .rd_en(rd_en),
    .addr_hi(addr_hi), .wdata(wdata), .rdata(rdata), .irq(irq), .tout(tout));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    rd_seen <= rd_en;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check("scoreboard underflow", 1, 0);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic rd(input bit hi, input logic [7:0] exp, input string tag);
    addr_hi = hi; rd_en = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input bit hi, input logic [7:0] d);
    addr_hi = hi; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_en(input bit v);
    en = v;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // waits for an irq sample; checks latency from ref and width of one cycle
  task automatic wait_irq(input int ref_c, input int lat, input logic exp_tout, input string tag);
    int t = -1;
    for (int i = 0; i < 400 && t < 0; i++) begin
      if (irq) t = cyc; else @(negedge clk);
    end
    check({tag, " latency"}, t - ref_c, lat);
    check({tag, " tout"}, tout, exp_tout);
    @(negedge clk);
    check({tag, " irq width"}, irq, 0);
  endtask

  task automatic measure(input logic [1:0] cs, input logic [15:0] rl, input int period, input string tag);
    int e;
    set_en(0);
    csel = cs;
    wr(1, rl[15:8]); wr(0, rl[7:0]);
    check({tag, " tout standby"}, tout, 0);
    set_en(1);
    e = cyc;
    wait_irq(e, (rl + 1) * period, 1'b1, {tag, " first"});
    wait_irq(e, 2 * (rl + 1) * period, 1'b0, {tag, " second"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int w;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check("R1 irq", irq, 0); check("R1 tout", tout, 0); check("R1 rdata", rdata, 0);
    rd(0, 8'h00, "R1 cnt lo"); rd(1, 8'h00, "R1 cnt hi");

    wr(1, 8'h12); wr(0, 8'h34);
    rd(0, 8'h34, "R2 lo"); rd(1, 8'h12, "R2 hi");
    wr(1, 8'hAB);
    rd(0, 8'h34, "R2 staged lo"); rd(1, 8'h12, "R2 staged hi");
    wr(0, 8'h56);
    rd(0, 8'h56, "R2 commit lo"); rd(1, 8'hAB, "R2 commit hi");

    // R3/R7: reload 0x0100 at tick period 2, enable at edge E
    wr(1, 8'h01); wr(0, 8'h00);
    csel = 2'd0;
    set_en(1);
    rd(0, 8'h00, "R7 loaded lo");
    idle(1);
    rd(1, 8'h01, "R3 latched hi");
    rd(0, 8'hFF, "R4 decremented lo");
    rd(1, 8'h00, "R3 latch after borrow");
    set_en(0);
    check("R8 tout low", tout, 0);
    idle(10);
    rd(0, 8'hFE, "R8 held lo"); rd(1, 8'h00, "R8 held hi");
    set_en(1);
    rd(0, 8'h00, "R8 reload kept lo"); rd(1, 8'h01, "R8 reload kept hi");
    set_en(0);

    measure(2'd0, 16'd2, 2, "R4 csel0");
    measure(2'd1, 16'd3, 8, "R4 csel1");
    measure(2'd2, 16'd1, 32, "R4 csel2");
    measure(2'd0, 16'd0, 2, "R9 zero reload");
    wait_irq(cyc - 1, 2, 1'b1, "R5 back-to-back");

    set_en(0);
    csel = 2'd3;
    wr(1, 8'h00); wr(0, 8'h05);
    set_en(1);
    idle(100);
    rd(0, 8'h05, "R4 csel3 no tick");
    check("R4 csel3 irq", irq, 0);

    set_en(0);
    csel = 2'd1;
    wr(1, 8'h00); wr(0, 8'h10);
    set_en(1);
    idle(20);
    wr(1, 8'h00); wr(0, 8'h03);
    w = cyc;
    wait_irq(w, 32, 1'b1, "R10 restart");
    set_en(0);
    idle(3);
    check("R1 scoreboard drained", exp_q.size(), 0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule